// File: doc/BRIEF.md
# Supply and Watchdog Reset Generator

This block creates the system reset for a processor. It takes two reset sources. The first is a supply-low flag that an external comparator has already turned into a digital level. The second is a watchdog strobe that processor firmware toggles to show it is still running. Reset is held for as long as the supply is low. When the supply recovers, reset is stretched for a fixed number of timebase ticks. If the strobe stays at one level for too long, a reset pulse of the same fixed length is issued.

All timing is counted in ticks of a slow timebase strobe that is supplied from outside, so both timeouts are parameters in tick units. The block is clocked and uses a synchronous active-low system reset. The supply-low flag is assumed to be synchronous to the clock already. The watchdog strobe is asynchronous and is synchronized inside the block. Reset is driven on two outputs, one of each polarity, and they always carry the same state.

Top module: `supv_reset_gen`

## Requirements
- R1: While `supply_low_i` is 1, `rst_out_n` is 0 from the first clock edge that samples the flag high.
- R2: Once `supply_low_i` is 0, reset deasserts on the clock edge that samples the RST_TICKS-th `tick_i` pulse counted since the flag cleared.
- R3: A return of `supply_low_i` to 1 during the stretch re-asserts reset and restarts the stretch count from zero, so a further RST_TICKS ticks are needed after the flag clears again.
- R4: A rising edge and a falling edge of `wdog_i` each clear the watchdog count. The edge is seen after two synchronizer flops. An edge and a tick sampled in the same cycle leave the count at zero.
- R5: With reset deasserted, if WD_TICKS ticks pass with no `wdog_i` edge, reset asserts on the edge that samples the WD_TICKS-th tick and then lasts exactly RST_TICKS ticks. No input disables this.
- R6: While reset is asserted, the watchdog count is held at zero and ignores ticks. It starts counting from zero once reset deasserts.
- R7: With `wdog_i` stuck at one level, reset pulses repeat once every WD_TICKS + RST_TICKS ticks.
- R8: `rst_out` is always the exact inverse of `rst_out_n`.
- R9: While `rst_n` is 0, reset is asserted. After `rst_n` is released with `supply_low_i` at 0, the stretch counts RST_TICKS ticks from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| tick_i | input | 1 | One-cycle timebase strobe; all timeouts are counted in these ticks |
| supply_low_i | input | 1 | Digitized supply-below-threshold flag, synchronous to clk |
| wdog_i | input | 1 | Asynchronous watchdog strobe; either edge services the watchdog |
| rst_out_n | output | 1 | Active-low reset output |
| rst_out | output | 1 | Active-high reset output, inverse of rst_out_n |

## Verification
The bench builds the block with RST_TICKS = 5 and WD_TICKS = 8 and drives `tick_i` itself, one pulse per task call. Every timeout boundary can therefore be reached in a few dozen cycles and checked one tick before and one tick after. These short values make it possible to place a supply dip part-way through the stretch and to land a watchdog edge exactly on the tick that would otherwise expire the count. They also make it possible to walk two full periods with the strobe stuck.

// File: rtl/supv_pkg.sv
// Package: shared helpers for the supply/watchdog reset generator.
// Assumes: counters are sized to hold values 0 .. limit-1.
package supv_pkg;

    // Width of a counter that must hold values up to lim-1 (at least 1 bit).
    function automatic int cnt_width(input int lim);
        return (lim <= 2) ? 1 : $clog2(lim);
    endfunction

    // State of the reset generator.
    typedef enum logic [0:0] {
        RS_ASSERTED = 1'b1,
        RS_RELEASED = 1'b0
    } rst_state_e;

endpackage

// File: rtl/supv_edge_sync.sv
// Module: two-flop synchronizer plus a both-edge detector.
// Does: brings an asynchronous level into the clk domain and pulses edge_o
//       for one cycle after each change of the synchronized level.
// Assumes: the input is stable for at least two clk cycles between changes.
module supv_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Synchronize the input and keep the previous synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Any difference between the current and previous value is an edge.
    always_comb begin
        edge_o = sync_q ^ prev_q;
    end

endmodule

// File: rtl/supv_wdog.sv
// Module: watchdog tick counter.
// Does: counts timebase ticks between kicks. It raises expire_o in the cycle
//       that samples the WD_TICKS-th tick with no kick.
// Assumes: hold_i is high for the whole reset period. A kick wins over a
//          tick that comes in the same cycle.
module supv_wdog #(
    parameter int WD_TICKS = 1600,
    localparam int CW = supv_pkg::cnt_width(WD_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          kick_i,
    input  logic          hold_i,
    output logic          expire_o,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Expire when the last tick arrives with no hold and no kick.
    always_comb begin
        expire_o = !hold_i && !kick_i && tick_i && (cnt_q == LAST);
    end

    // Clear on hold, kick or expiry; otherwise advance on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold_i || kick_i || expire_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/supv_stretch.sv
// Module: reset state and stretch counter.
// Does: asserts reset while the supply is low or when the watchdog expires.
//       It then keeps reset asserted for RST_TICKS ticks before releasing it.
// Assumes: supply_low_i is synchronous to clk.
module supv_stretch #(
    parameter int RST_TICKS = 200,
    localparam int CW = supv_pkg::cnt_width(RST_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          supply_low_i,
    input  logic          wd_expire_i,
    output logic          reset_act_o,
    output logic [CW-1:0] cnt_o
);

    import supv_pkg::*;

    localparam logic [CW-1:0] LAST = CW'(RST_TICKS - 1);

    rst_state_e    state_q;
    logic [CW-1:0] cnt_q;

    // Next state: a trigger restarts the stretch; ticks advance it to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_ASSERTED;
            cnt_q   <= '0;
        end else if (supply_low_i || wd_expire_i) begin
            state_q <= RS_ASSERTED;
            cnt_q   <= '0;
        end else if (state_q == RS_ASSERTED && tick_i) begin
            if (cnt_q == LAST) begin
                state_q <= RS_RELEASED;
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    assign reset_act_o = (state_q == RS_ASSERTED);
    assign cnt_o       = cnt_q;

endmodule

// File: rtl/supv_reset_gen.sv
// Module: supply and watchdog reset generator (top).
// Does: combines the supply-low hold, the reset stretch and the watchdog
//       into one reset that is driven in both polarities.
// Assumes: tick_i is a one-cycle strobe; timeouts are counted in ticks.
module supv_reset_gen #(
    parameter int RST_TICKS = 200,
    parameter int WD_TICKS  = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic supply_low_i,
    input  logic wdog_i,
    output logic rst_out_n,
    output logic rst_out
);

    localparam int SCW = supv_pkg::cnt_width(RST_TICKS);
    localparam int WCW = supv_pkg::cnt_width(WD_TICKS);

    logic           wd_edge;
    logic           wd_expire;
    logic           reset_act;
    logic [SCW-1:0] stretch_cnt;
    logic [WCW-1:0] wd_cnt;

    supv_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (wdog_i),
        .edge_o  (wd_edge)
    );

    supv_wdog #(.WD_TICKS(WD_TICKS)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .kick_i   (wd_edge),
        .hold_i   (reset_act),
        .expire_o (wd_expire),
        .cnt_o    (wd_cnt)
    );

    supv_stretch #(.RST_TICKS(RST_TICKS)) u_stretch (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .supply_low_i (supply_low_i),
        .wd_expire_i  (wd_expire),
        .reset_act_o  (reset_act),
        .cnt_o        (stretch_cnt)
    );

    // Drive both output polarities from the single reset state.
    always_comb begin
        rst_out   = reset_act;
        rst_out_n = ~reset_act;
    end

endmodule

// File: rtl/supv_reset_gen_chk.sv
// Module: property checker for supv_reset_gen, attached with bind.
// Does: checks the timing relations between the inputs, the outputs and the
//       internal counters.
// Assumes: it is bound to every instance of the top module.
module supv_reset_gen_chk #(
    parameter int SCW = 1,
    parameter int WCW = 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_i,
    input logic           supply_low_i,
    input logic           rst_out,
    input logic           rst_out_n,
    input logic           wd_edge,
    input logic           wd_expire,
    input logic [SCW-1:0] stretch_cnt,
    input logic [WCW-1:0] wd_cnt
);

    // R1: supply low asserts reset at the next edge
    a_r1_supply_holds: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low_i |=> !rst_out_n);

    // R2: release only on a sampled tick with the supply good
    a_r2_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> ($past(tick_i) && !$past(supply_low_i)));

    // R3: a new dip restarts the stretch from zero
    a_r3_dip_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_low_i) |=> (stretch_cnt == '0 && rst_out));

    // R4: an edge clears the watchdog count
    a_r4_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wd_edge |=> (wd_cnt == '0));

    // R5: expiry asserts reset
    a_r5_expire_resets: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> rst_out);

    // R6: watchdog held at zero during reset
    a_r6_wd_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> (wd_cnt == '0));

    // R8: outputs stay complementary
    a_r8_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out != rst_out_n);

endmodule

bind supv_reset_gen supv_reset_gen_chk #(.SCW(SCW), .WCW(WCW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .supply_low_i (supply_low_i),
    .rst_out      (rst_out),
    .rst_out_n    (rst_out_n),
    .wd_edge      (wd_edge),
    .wd_expire    (wd_expire),
    .stretch_cnt  (stretch_cnt),
    .wd_cnt       (wd_cnt)
);

// File: tb/supv_reset_gen_tb.sv
// Bench: directed scenarios for supv_reset_gen. Each task checks its own results.
module supv_reset_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RST_T      = 5;
    localparam int WD_T       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic supply_low_i = 1'b0;
    logic wdog_i = 1'b0;
    logic rst_out_n;
    logic rst_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supv_reset_gen #(.RST_TICKS(RST_T), .WD_TICKS(WD_T)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .supply_low_i (supply_low_i),
        .wdog_i       (wdog_i),
        .rst_out_n    (rst_out_n),
        .rst_out      (rst_out)
    );

    // Check both outputs against the expected reset level (R8 every time).
    task automatic check_rst(input bit exp, input string req);
        n_tests++;
        if (rst_out !== exp || rst_out_n !== !exp) begin
            n_fail++;
            $display("FAIL %s: rst_out=%b rst_out_n=%b expected rst_out=%b rst_out_n=%b (R8)",
                     req, rst_out, rst_out_n, exp, !exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One tick pulse sampled at the next posedge; returns at a negedge.
    task automatic tick();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Toggle the watchdog and let the edge pass through the synchronizer.
    task automatic kick();
        wdog_i = ~wdog_i;
        idle(4);
    endtask

    // R9: reset state and power-on stretch.
    task automatic t_power_on();
        rst_n = 1'b0;
        supply_low_i = 1'b0;
        idle(3);
        check_rst(1'b1, "R9 reset state");
        ticks(RST_T);
        check_rst(1'b1, "R9 ticks ignored in system reset");
        rst_n = 1'b1;
        idle(1);
        ticks(RST_T - 1);
        check_rst(1'b1, "R9 stretch one tick short");
        tick();
        check_rst(1'b0, "R9 stretch released");
    endtask

    // R1 and R2: hold while low, then release after RST_T ticks.
    task automatic t_supply_hold();
        supply_low_i = 1'b1;
        @(negedge clk);
        check_rst(1'b1, "R1 assert next edge");
        ticks(RST_T + 3);
        check_rst(1'b1, "R1 held while low");
        supply_low_i = 1'b0;
        idle(2);
        ticks(RST_T - 1);
        check_rst(1'b1, "R2 one tick before release");
        tick();
        check_rst(1'b0, "R2 release at RST_T-th tick");
    endtask

    // R3: a dip part-way through restarts the stretch.
    task automatic t_dip_restart();
        supply_low_i = 1'b1;
        idle(2);
        supply_low_i = 1'b0;
        ticks(3);
        supply_low_i = 1'b1;
        @(negedge clk);
        check_rst(1'b1, "R3 dip asserted");
        supply_low_i = 1'b0;
        ticks(RST_T - 1);
        check_rst(1'b1, "R3 count restarted");
        tick();
        check_rst(1'b0, "R3 released after full count");
    endtask

    // R4: both edges kick, and a kick wins over a coincident tick.
    task automatic t_kicks();
        kick();
        ticks(WD_T - 1);
        kick();
        check_rst(1'b0, "R4 kick in time");
        ticks(WD_T - 1);
        kick();
        check_rst(1'b0, "R4 opposite edge kick");
        ticks(WD_T - 1);
        wdog_i = ~wdog_i;
        idle(2);
        tick();
        check_rst(1'b0, "R4 edge beats coincident tick");
        idle(2);
        ticks(WD_T - 1);
        check_rst(1'b0, "R4 count restarted at zero");
        tick();
        check_rst(1'b1, "R5 expiry after WD_T ticks");
        ticks(RST_T - 1);
        check_rst(1'b1, "R5 pulse one tick short");
        tick();
        check_rst(1'b0, "R5 pulse length RST_T");
    endtask

    // R5, R6 and R7: stuck strobe gives a periodic pulse; no count during reset.
    task automatic t_stuck();
        kick();
        ticks(WD_T - 1);
        check_rst(1'b0, "R5 not yet expired");
        tick();
        check_rst(1'b1, "R5 expired");
        ticks(RST_T);
        check_rst(1'b0, "R7 first pulse ended");
        ticks(WD_T - 1);
        check_rst(1'b0, "R6 no counting during reset");
        tick();
        check_rst(1'b1, "R7 second pulse at WD_T+RST_T");
        ticks(RST_T);
        check_rst(1'b0, "R7 second pulse ended");
    endtask

    initial begin
        t_power_on();
        t_supply_hold();
        t_dip_restart();
        t_kicks();
        t_stuck();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule